// File: doc/BRIEF.md
# Serial Flash Dual-Read Responder

This block acts as the device end of a serial flash read link. It is placed in a design as a synthesizable read target. A host drives chip select (active low), a serial clock and a command line. The responder samples these pins with its own system clock and finds the edges of the serial clock. It then takes an 8-bit command code, followed by a 24-bit start address sent most significant bit first.

Two commands are recognised. With code 03h, bytes are returned one bit per serial clock on the IO1 line. With code 3Bh, eight dummy clocks follow the address, and after them bytes are returned two bits per serial clock on IO1 and IO0. Bytes come from an external byte-wide memory with a synchronous read port. The address advances after each byte, and after the top of the 2 MiB space it wraps to zero. Any other code makes the block stay silent until chip select rises. Raising chip select ends a read at once, even in the middle of a byte, and releases both lines.

Outputs change only after a falling serial-clock edge, so the host can sample them on the next rising edge. The next byte is fetched from memory while the current byte is still being shifted out, so bytes follow each other with no gap.

Top module: `sflash_dual_rd_resp`

## Requirements
- R1: While reset is held and just after it, io1_oe, io0_oe and mem_rd_en are all 0.
- R2: Command 03h returns each byte on io1_out, bit 7 first, one bit per serial clock, with io1_oe at 1 and io0_oe at 0. The output bits change only after a falling edge of sck.
- R3: After the address, command 3Bh takes eight dummy clocks, and during them both output enables stay 0. Each byte is then sent as four pairs, one pair per clock. The first pair is (io1_out, io0_out) = (bit 7, bit 6), then bits 5 and 4, and so on. io0_oe is never 1 while io1_oe is 0.
- R4: The 24 address bits arrive on si most significant bit first, sampled on rising edges of sck. Address bits 23 down to 21 are ignored, so address A reads memory location A mod 2^21.
- R5: While chip select stays low, each later byte comes from the next address, with no idle clocks between bytes.
- R6: The byte after address 1FFFFFh is read from address 000000h, with no extra clocks.
- R7: Within 4 system clocks after cs_n rises, both output enables are 0, and any partly sent byte is dropped. The next falling edge of cs_n starts a new command at its first bit.
- R8: With any command code other than 03h or 3Bh, the block drives no output enable and issues no memory read until cs_n rises.
- R9: mem_rd_en is a single-cycle pulse, and mem_rdata is taken one system clock after that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select from the host, active low |
| sck | input | 1 | Serial clock from the host, low while idle |
| si | input | 1 | Command, address and dummy bits from the host |
| mem_rd_en | output | 1 | Memory read strobe, one cycle |
| mem_addr | output | 21 | Memory byte address |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the strobe |
| io1_out | output | 1 | Data value for line IO1 |
| io1_oe | output | 1 | Drive enable for line IO1 |
| io0_out | output | 1 | Data value for line IO0 |
| io0_oe | output | 1 | Drive enable for line IO0 |

## Verification
The assertions assume that cs_n, sck and si are slow compared with clk. Each serial-clock half period must last several system clocks. sck must be low whenever cs_n changes. The memory must answer one cycle after each strobe. The bench meets these conditions by changing the host pins only on falling edges of clk and by holding each sck level for eight system clocks. It also waits several clocks after every chip-select change, so every edge passes through the synchronizers before the next one arrives.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_SKIP
  } sfr_state_e;

  localparam logic [7:0] CMD_READ_X1 = 8'h03;
  localparam logic [7:0] CMD_READ_X2 = 8'h3B;
endpackage

// File: rtl/sfr_sync_edge.sv
module sfr_sync_edge #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_ch
    logic [STAGES:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= '0;
      else     pipe <= {pipe[STAGES-1:0], din[g]};
    end
    assign level[g] = pipe[STAGES-1];
    assign rise[g]  = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall[g]  = ~pipe[STAGES-1] & pipe[STAGES];
  end
endmodule

// File: rtl/sfr_cmd_ctrl.sv
module sfr_cmd_ctrl
  import sfr_pkg::*;
#(
  parameter int ARRAY_AW = 21,
  parameter int CMD_AW   = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_hi,
  input  logic                cs_fall,
  input  logic                sck_rise,
  input  logic                sck_fall,
  input  logic                si_s,
  output logic                mem_rd_en,
  output logic [ARRAY_AW-1:0] mem_addr,
  input  logic [7:0]          mem_rdata,
  output logic                ld_byte,
  output logic                sh_bits,
  output logic                dual,
  output logic [7:0]          nxt_byte
);
  localparam int CW = $clog2(CMD_AW + 1);

  sfr_state_e          state;
  logic [CW-1:0]       cnt;
  logic [CMD_AW-1:0]   shreg;
  logic [2:0]          pair;
  logic                rd_vld;
  logic [7:0]          opc_now;
  logic                active;

  assign opc_now  = {shreg[6:0], si_s};
  assign active   = ~cs_hi & ~cs_fall & sck_fall & (state == ST_DATA);
  assign ld_byte  = active & (pair == 3'd0);
  assign sh_bits  = active & (pair != 3'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      pair      <= '0;
      dual      <= 1'b0;
      mem_addr  <= '0;
      mem_rd_en <= 1'b0;
      rd_vld    <= 1'b0;
      nxt_byte  <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      rd_vld    <= mem_rd_en;
      if (rd_vld)    nxt_byte <= mem_rdata;
      if (mem_rd_en) mem_addr <= mem_addr + 1'b1;
      if (cs_hi) begin
        state <= ST_IDLE;
      end else if (cs_fall) begin
        state <= ST_OPC;
        cnt   <= '0;
        pair  <= '0;
      end else if (sck_rise) begin
        case (state)
          ST_OPC: begin
            shreg <= {shreg[CMD_AW-2:0], si_s};
            cnt   <= cnt + 1'b1;
            if (cnt == CW'(7)) begin
              cnt <= '0;
              if (opc_now == CMD_READ_X1) begin
                state <= ST_ADDR;
                dual  <= 1'b0;
              end else if (opc_now == CMD_READ_X2) begin
                state <= ST_ADDR;
                dual  <= 1'b1;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_ADDR: begin
            shreg <= {shreg[CMD_AW-2:0], si_s};
            cnt   <= cnt + 1'b1;
            if (cnt == CW'(CMD_AW - 1)) begin
              cnt       <= '0;
              pair      <= '0;
              mem_addr  <= {shreg[ARRAY_AW-2:0], si_s};
              mem_rd_en <= 1'b1;
              state     <= dual ? ST_DUMMY : ST_DATA;
            end
          end
          ST_DUMMY: begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(7)) begin
              cnt   <= '0;
              state <= ST_DATA;
            end
          end
          default: ;
        endcase
      end else if (active) begin
        if (ld_byte) mem_rd_en <= 1'b1;
        if (dual) pair <= {1'b0, pair[1:0] + 2'd1};
        else      pair <= pair + 3'd1;
      end
    end
  end

  assert_skip_no_read_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> !mem_rd_en);
  assert_rd_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);
  assert_idle_no_read_R7: assert property (@(posedge clk) disable iff (rst)
    $past(cs_hi) && cs_hi |-> !mem_rd_en);
endmodule

// File: rtl/sfr_out_ser.sv
module sfr_out_ser (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       shift,
  input  logic       dual,
  input  logic       oe_clr,
  input  logic [7:0] din,
  output logic       io1_out,
  output logic       io0_out,
  output logic       io1_oe,
  output logic       io0_oe
);
  logic [7:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg    <= '0;
      io1_out <= 1'b0;
      io0_out <= 1'b0;
      io1_oe  <= 1'b0;
      io0_oe  <= 1'b0;
    end else begin
      if (load) begin
        io1_out <= din[7];
        io0_out <= din[6];
        sreg    <= dual ? {din[5:0], 2'b00} : {din[6:0], 1'b0};
      end else if (shift) begin
        io1_out <= sreg[7];
        io0_out <= sreg[6];
        sreg    <= dual ? {sreg[5:0], 2'b00} : {sreg[6:0], 1'b0};
      end
      if (oe_clr) begin
        io1_oe <= 1'b0;
        io0_oe <= 1'b0;
      end else if (load) begin
        io1_oe <= 1'b1;
        io0_oe <= dual;
      end
    end
  end

  assert_oe_release_R7: assert property (@(posedge clk) disable iff (rst)
    oe_clr |=> !io1_oe && !io0_oe);
  assert_io0_needs_io1_R3: assert property (@(posedge clk) disable iff (rst)
    io0_oe |-> io1_oe);
  assert_single_io0_off_R2: assert property (@(posedge clk) disable iff (rst)
    (io1_oe && !dual) |-> !io0_oe);
  assert_out_after_fall_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable({io1_out, io0_out}) |-> $past(load || shift));
endmodule

// File: rtl/sflash_dual_rd_resp.sv
module sflash_dual_rd_resp #(
  parameter int ARRAY_AW    = 21,
  parameter int CMD_AW      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_n,
  input  logic                sck,
  input  logic                si,
  output logic                mem_rd_en,
  output logic [ARRAY_AW-1:0] mem_addr,
  input  logic [7:0]          mem_rdata,
  output logic                io1_out,
  output logic                io1_oe,
  output logic                io0_out,
  output logic                io0_oe
);
  logic [2:0] lvl, rse, fll;
  logic       ld_byte, sh_bits, dual;
  logic [7:0] nxt_byte;

  sfr_sync_edge #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din({si, sck, cs_n}),
    .level(lvl), .rise(rse), .fall(fll)
  );

  sfr_cmd_ctrl #(.ARRAY_AW(ARRAY_AW), .CMD_AW(CMD_AW)) u_ctrl (
    .clk(clk), .rst(rst),
    .cs_hi(lvl[0]), .cs_fall(fll[0]),
    .sck_rise(rse[1]), .sck_fall(fll[1]), .si_s(lvl[2]),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .ld_byte(ld_byte), .sh_bits(sh_bits), .dual(dual), .nxt_byte(nxt_byte)
  );

  sfr_out_ser u_ser (
    .clk(clk), .rst(rst), .load(ld_byte), .shift(sh_bits), .dual(dual),
    .oe_clr(lvl[0]), .din(nxt_byte),
    .io1_out(io1_out), .io0_out(io0_out), .io1_oe(io1_oe), .io0_oe(io0_oe)
  );
endmodule

// File: tb/tb_sflash_dual_rd_resp.sv
module tb_sflash_dual_rd_resp;
  localparam int AW   = 21;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rdata = '0;
  logic io1_out, io1_oe, io0_out, io0_oe;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R2";
  int exp_q[$];
  int got_q[$];
  bit skip_mon = 0;
  int skip_bad = 0;

  always #4 clk = ~clk;

  sflash_dual_rd_resp dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .io1_out(io1_out), .io1_oe(io1_oe), .io0_out(io0_out), .io0_oe(io0_oe)
  );

  function automatic logic [7:0] memv(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {a[20:16], 3'b101};
  endfunction

  always_ff @(posedge clk) if (mem_rd_en) mem_rdata <= memv(mem_addr);

  always @(negedge clk)
    if (skip_mon && (io1_oe || io0_oe || mem_rd_en)) skip_bad++;

  always @(negedge clk) begin
    while (got_q.size() > 0) begin
      int g, e;
      g = got_q.pop_front();
      e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
      checks++;
      if (g != e) begin
        errors++;
        $display("FAIL %s: byte got %02h expected %02h", cur_req, g, e);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bit_cyc(input logic din, output logic o1, output logic o0);
    si = din;
    repeat (HALF) @(negedge clk);
    o1 = io1_out;
    o0 = io0_out;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic a, c;
    for (int i = 7; i >= 0; i--) bit_cyc(b[i], a, c);
  endtask

  task automatic cs_start();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_stop(input string req);
    cs_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(req, {io1_oe, io0_oe}, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic read_tx(input string req, input logic [7:0] op,
                         input logic [23:0] a, input int n, input int partial_bits);
    logic o1, o0;
    logic [7:0] b;
    int bad_oe = 0;
    bit dl = (op == 8'h3B);
    cur_req = req;
    cs_start();
    send_byte(op);
    send_byte(a[23:16]);
    send_byte(a[15:8]);
    send_byte(a[7:0]);
    if (dl) begin
      for (int i = 0; i < 8; i++) begin
        bit_cyc(1'b0, o1, o0);
        if (io1_oe || io0_oe) bad_oe++;
      end
      chk("R3 dummy oe", bad_oe, 0);
    end
    for (int k = 0; k < n; k++) begin
      logic [AW-1:0] ea = a[AW-1:0] + AW'(k);
      exp_q.push_back(int'(memv(ea)));
      b = '0;
      if (dl) begin
        for (int p = 0; p < 4; p++) begin
          bit_cyc(1'b0, o1, o0);
          b = {b[5:0], o1, o0};
        end
      end else begin
        for (int p = 0; p < 8; p++) begin
          bit_cyc(1'b0, o1, o0);
          b = {b[6:0], o1};
        end
      end
      if (k == 0) chk({req, " oe"}, {io1_oe, io0_oe}, dl ? 3 : 2);
      got_q.push_back(int'(b));
      @(negedge clk);
    end
    for (int p = 0; p < partial_bits; p++) bit_cyc(1'b0, o1, o0);
    cs_stop("R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {io1_oe, io0_oe, mem_rd_en}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 after reset", {io1_oe, io0_oe, mem_rd_en}, 0);

    read_tx("R2 single", 8'h03, 24'h012345, 3, 0);
    read_tx("R3 dual", 8'h3B, 24'h00A5C3, 3, 0);
    read_tx("R4 high bits ignored", 8'h03, 24'hE01234, 2, 0);
    read_tx("R5 stream", 8'h3B, 24'h0000FD, 6, 0);
    read_tx("R6 wrap single", 8'h03, 24'h1FFFFE, 4, 0);
    read_tx("R6 wrap dual", 8'h3B, 24'hFFFFFF, 3, 0);

    cur_req = "R8";
    cs_start();
    skip_mon = 1;
    send_byte(8'h9F);
    for (int i = 0; i < 5; i++) send_byte(8'hFF);
    skip_mon = 0;
    chk("R8 unknown opcode activity", skip_bad, 0);
    cs_stop("R8");

    read_tx("R7 abort mid byte", 8'h3B, 24'h054321, 1, 2);
    read_tx("R7 restart after abort", 8'h03, 24'h0ABCDE, 2, 3);
    read_tx("R9 fetch after abort", 8'h3B, 24'h1F00F0, 2, 0);

    repeat (4) @(negedge clk);
    chk("R9 queue drained", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule